// File: doc/BRIEF.md
# Receive FIFO with Per-Character Status

This block is the receive-side buffer of one asynchronous serial channel. Characters assembled by the receive shift register arrive one per write strobe, each with its break, framing and parity flags. Every character is stored together with its own three flags. The entry at the head of the queue is shown on the output together with those flags, so error status always belongs to the character about to be read.

The buffer holds up to 16 characters, or 8 when the half-depth mode input is high. It drives ready, full and sticky overrun indications and a fill-level interrupt request. The fill-level threshold is programmable. An unread-data watchdog raises a separate request when characters sit in the queue for too long. Two commands are accepted. The receiver reset empties the queue. The error reset clears the stored flags and the overrun flag.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the queue is empty: `ready_o`=0, `full_o`=0, `overrun_o`=0, head outputs 0. `ready_o` is 1 whenever at least one character is held. `full_o` is 1 when the held count is at least the current capacity, which is 16 by default.
- R2: While `half_depth_i`=1 the capacity is 8. Writes beyond 8 held characters are refused. `full_o` follows the current capacity combinationally.
- R3: A write that arrives while the queue is full is dropped and the stored contents are kept. This holds even when a read happens in the same cycle. `overrun_o` then goes to 1 on the next edge and stays 1 until an error reset.
- R4: Characters leave in arrival order. `head_data_o`, `head_brk_o`, `head_frm_o` and `head_par_o` show the oldest held entry and the flags written with it. They show 0 when the queue is empty.
- R5: `cmd_err_reset_i` clears the break, framing and parity flags of every held entry and clears `overrun_o`. The data is kept. A character written in the same cycle keeps its own flags.
- R6: `cmd_rx_reset_i` empties the queue and resets both pointers, so `ready_o` and the head flags read 0 after the edge. Any read or write in that cycle is discarded. `overrun_o` is not changed by it.
- R7: `fill_irq_o` is 1 when the held count is at least the threshold chosen by the active level code. The codes are 0 for one character, 1 for half the capacity, 2 for three quarters of the capacity and 3 for the full capacity. The threshold is scaled to the current capacity.
- R8: A level written with `lvl_wr_i` while the queue is empty becomes active on that edge. Otherwise it is held pending and becomes active at the first later edge on which a character is pushed or popped.
- R9: The watchdog counts `char_tick_i` pulses while the queue is non-empty and no push or pop occurs. After 64 such pulses it sets a flag, and `wd_irq_o` is that flag gated by `wd_en_i`. Any push, any pop, an empty queue or a receiver reset restarts the count and clears the flag.
- R10: A read strobe while the queue is empty has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Assembled character present |
| wr_data_i | input | 8 | Character data |
| wr_brk_i | input | 1 | Break flag of the character |
| wr_frm_i | input | 1 | Framing-error flag of the character |
| wr_par_i | input | 1 | Parity-error flag of the character |
| rd_i | input | 1 | CPU read of the head entry |
| half_depth_i | input | 1 | 1 selects 8-entry capacity |
| lvl_wr_i | input | 1 | Program the fill level |
| lvl_i | input | 2 | Fill-level code |
| wd_en_i | input | 1 | Watchdog interrupt enable |
| char_tick_i | input | 1 | One pulse per character time |
| cmd_rx_reset_i | input | 1 | Receiver reset command |
| cmd_err_reset_i | input | 1 | Error-status reset command |
| head_data_o | output | 8 | Head entry data |
| head_brk_o | output | 1 | Head entry break flag |
| head_frm_o | output | 1 | Head entry framing flag |
| head_par_o | output | 1 | Head entry parity flag |
| ready_o | output | 1 | At least one character held |
| full_o | output | 1 | Held count at capacity |
| overrun_o | output | 1 | Sticky overrun |
| fill_irq_o | output | 1 | Fill-level request |
| wd_irq_o | output | 1 | Watchdog request |

## Verification
The hardest situation to reach is a fill level left pending while characters are held, because it only becomes active on a later push or pop. The stimulus programs a new level on an empty queue and again on a partly filled one. It then leaves a gap before the next write, so the old and new thresholds disagree during that gap. The watchdog expiry is also hard to reach, since it needs 64 quiet character ticks with data held. The bench holds data with ticks on every cycle and interrupts one run with a read just before expiry to show that the count restarts. Overrun is driven with a simultaneous read on a full queue, and with the capacity switched from 16 to 8 while more than 8 characters are held.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  typedef enum logic [1:0] {
    LVL_ONE  = 2'd0,
    LVL_HALF = 2'd1,
    LVL_3Q   = 2'd2,
    LVL_FULL = 2'd3
  } fill_lvl_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clr_i,
  input  logic          err_clr_i,
  input  rx_char_t      din_i,
  output rx_char_t      head_o,
  output logic [CW-1:0] count_o
);
  rx_char_t        mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (err_clr_i) begin
        for (int i = 0; i < DEPTH; i++) begin
          mem[i].brk <= 1'b0;
          mem[i].frm <= 1'b0;
          mem[i].par <= 1'b0;
        end
      end
      // pushed entry keeps its own flags even under error clear
      if (push_i) begin
        mem[wp] <= din_i;
        wp      <= wp + PW'(1);
      end
      if (pop_i) rp <= rp + PW'(1);
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = (cnt != '0) ? mem[rp] : '0;
  assign count_o = cnt;
endmodule

// File: rtl/rxf_fill_level.sv
module rxf_fill_level
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  fill_lvl_e     lvl_i,
  input  logic          upd_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] cap_i,
  output logic          irq_o
);
  fill_lvl_e     act_q, pend_q;
  logic          pend_v;
  logic [CW-1:0] thr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= LVL_ONE;
      pend_q <= LVL_ONE;
      pend_v <= 1'b0;
    end else if (set_i) begin
      if (count_i == '0) begin
        act_q  <= lvl_i;
        pend_v <= 1'b0;
      end else begin
        pend_q <= lvl_i;
        pend_v <= 1'b1;
      end
    end else if (pend_v && upd_i) begin
      act_q  <= pend_q;
      pend_v <= 1'b0;
    end
  end

  always_comb begin
    unique case (act_q)
      LVL_ONE:  thr = CW'(1);
      LVL_HALF: thr = cap_i >> 1;
      LVL_3Q:   thr = cap_i - (cap_i >> 2);
      default:  thr = cap_i;
    endcase
  end

  assign irq_o = (count_i >= thr);
endmodule

// File: rtl/rxf_watchdog.sv
module rxf_watchdog #(
  parameter int WD_CHARS = 64,
  localparam int TW = $clog2(WD_CHARS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic en_i,
  output logic irq_o
);
  logic [TW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (restart_i) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (tick_i && !fired) begin
      cnt <= cnt + TW'(1);
      if (cnt == TW'(WD_CHARS - 1)) fired <= 1'b1;
    end
  end

  assign irq_o = en_i & fired;
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int WD_CHARS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_brk_i,
  input  logic              wr_frm_i,
  input  logic              wr_par_i,
  input  logic              rd_i,
  input  logic              half_depth_i,
  input  logic              lvl_wr_i,
  input  logic [1:0]        lvl_i,
  input  logic              wd_en_i,
  input  logic              char_tick_i,
  input  logic              cmd_rx_reset_i,
  input  logic              cmd_err_reset_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_brk_o,
  output logic              head_frm_o,
  output logic              head_par_o,
  output logic              ready_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              fill_irq_o,
  output logic              wd_irq_o
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic [CW-1:0] count, cap;
  logic          push, pop, ovr_q;
  rx_char_t      din, head;

  assign cap  = half_depth_i ? CW'(HALF) : CW'(DEPTH);
  assign push = wr_valid_i && (count < cap) && !cmd_rx_reset_i;
  assign pop  = rd_i && (count != '0) && !cmd_rx_reset_i;
  assign din  = '{brk: wr_brk_i, frm: wr_frm_i, par: wr_par_i, data: wr_data_i};

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop), .clr_i(cmd_rx_reset_i), .err_clr_i(cmd_err_reset_i),
    .din_i(din), .head_o(head), .count_o(count)
  );

  rxf_fill_level #(.DEPTH(DEPTH)) u_fill (
    .clk_i, .rst_ni,
    .set_i(lvl_wr_i), .lvl_i(fill_lvl_e'(lvl_i)), .upd_i(push | pop),
    .count_i(count), .cap_i(cap), .irq_o(fill_irq_o)
  );

  rxf_watchdog #(.WD_CHARS(WD_CHARS)) u_wd (
    .clk_i, .rst_ni,
    .restart_i(push | pop | (count == '0) | cmd_rx_reset_i),
    .tick_i(char_tick_i), .en_i(wd_en_i), .irq_o(wd_irq_o)
  );

  // overrun is sticky; rx reset leaves it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovr_q <= 1'b0;
    else if (cmd_err_reset_i)             ovr_q <= 1'b0;
    else if (wr_valid_i && count >= cap)  ovr_q <= 1'b1;
  end

  assign head_data_o = head.data;
  assign head_brk_o  = head.brk;
  assign head_frm_o  = head.frm;
  assign head_par_o  = head.par;
  assign ready_o     = (count != '0);
  assign full_o      = (count >= cap);
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic       rd_i,
  input logic       cmd_rx_reset_i,
  input logic       cmd_err_reset_i,
  input logic [7:0] head_data_o,
  input logic       ready_o,
  input logic       full_o,
  input logic       overrun_o,
  input logic       wd_irq_o
);
  assert_full_has_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> ready_o);

  assert_overrun_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full_o && !cmd_err_reset_i) |=> overrun_o);

  assert_overrun_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !cmd_err_reset_i) |=> overrun_o);

  assert_err_reset_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_reset_i |=> !overrun_o);

  assert_rx_reset_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rx_reset_i |=> !ready_o);

  assert_head_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !rd_i && !cmd_rx_reset_i) |=> $stable(head_data_o));

  assert_wd_needs_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_irq_o |-> ready_o);
endmodule

bind rx_status_fifo rxf_checker u_rxf_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_valid_i     (wr_valid_i),
  .rd_i           (rd_i),
  .cmd_rx_reset_i (cmd_rx_reset_i),
  .cmd_err_reset_i(cmd_err_reset_i),
  .head_data_o    (head_data_o),
  .ready_o        (ready_o),
  .full_o         (full_o),
  .overrun_o      (overrun_o),
  .wd_irq_o       (wd_irq_o)
);

// File: tb/tb_rx_status_fifo.sv
`timescale 1ns/1ps
module tb_rx_status_fifo;
  localparam int WD = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid = 0, wr_brk = 0, wr_frm = 0, wr_par = 0, rd = 0;
  logic [7:0] wr_data = '0;
  logic half = 0, lvl_wr = 0, wd_en = 0, tick = 0, rxr = 0, errr = 0;
  logic [1:0] lvl = '0;
  logic [7:0] h_data;
  logic h_brk, h_frm, h_par, ready, full, ovr, fill_irq, wd_irq;

  always #2.5 clk = ~clk;

  rx_status_fifo dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_brk_i(wr_brk), .wr_frm_i(wr_frm), .wr_par_i(wr_par),
    .rd_i(rd), .half_depth_i(half), .lvl_wr_i(lvl_wr), .lvl_i(lvl), .wd_en_i(wd_en),
    .char_tick_i(tick), .cmd_rx_reset_i(rxr), .cmd_err_reset_i(errr),
    .head_data_o(h_data), .head_brk_o(h_brk), .head_frm_o(h_frm), .head_par_o(h_par),
    .ready_o(ready), .full_o(full), .overrun_o(ovr), .fill_irq_o(fill_irq), .wd_irq_o(wd_irq)
  );

  typedef struct {int data; bit brk; bit frm; bit par;} ent_t;
  ent_t q[$];
  bit   m_ovr, m_wflag, m_pendv;
  int   m_act, m_pend, m_wcnt;
  int   total = 0, bad = 0;

  // behavioural reference, updated on each edge from pre-edge inputs
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete(); m_ovr = 0; m_wflag = 0; m_pendv = 0; m_act = 0; m_pend = 0; m_wcnt = 0;
    end else begin
      int n, cap; bit dpush, dpop;
      n = q.size(); cap = half ? 8 : 16;
      dpush = wr_valid && n < cap && !rxr;
      dpop  = rd && n > 0 && !rxr;
      if (errr) m_ovr = 0; else if (wr_valid && n >= cap) m_ovr = 1;
      if (lvl_wr) begin
        if (n == 0) begin m_act = lvl; m_pendv = 0; end
        else begin m_pend = lvl; m_pendv = 1; end
      end else if (m_pendv && (dpush || dpop)) begin m_act = m_pend; m_pendv = 0; end
      if (dpush || dpop || n == 0 || rxr) begin m_wcnt = 0; m_wflag = 0; end
      else if (tick && !m_wflag) begin m_wcnt++; if (m_wcnt == WD) m_wflag = 1; end
      if (rxr) q.delete();
      else begin
        if (errr) foreach (q[i]) begin q[i].brk = 0; q[i].frm = 0; q[i].par = 0; end
        if (dpop) void'(q.pop_front());
        if (dpush) q.push_back('{int'(wr_data), wr_brk, wr_frm, wr_par});
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    int cap, n, thr, hd;
    cap = half ? 8 : 16; n = q.size();
    case (m_act) 0: thr = 1; 1: thr = cap / 2; 2: thr = cap - cap / 4; default: thr = cap; endcase
    hd = (n > 0) ? (q[0].data | (q[0].brk << 8) | (q[0].frm << 9) | (q[0].par << 10)) : 0;
    chk("R1 R6 R10 ready", ready, n > 0);
    chk("R1 R2 full", full, n >= cap);
    chk("R4 R5 R6 head", {h_par, h_frm, h_brk, h_data}, hd);
    chk("R3 R5 overrun", ovr, m_ovr);
    chk("R7 R8 fill_irq", fill_irq, n >= thr);
    chk("R9 wd_irq", wd_irq, wd_en && m_wflag);
  end

  task automatic cyc(int k = 1);
    repeat (k) begin @(negedge clk); #1; end
  endtask

  task automatic push(int d);
    wr_valid = 1; wr_data = 8'(d); wr_brk = (d % 5 == 0); wr_frm = (d % 3 == 1); wr_par = d[0];
    cyc(); wr_valid = 0; wr_brk = 0; wr_frm = 0; wr_par = 0;
  endtask

  task automatic pop(); rd = 1; cyc(); rd = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(2); rst_ni = 1; cyc(2);
    // R1 reset state
    chk("R1 reset ready", ready, 0);
    chk("R1 reset overrun", ovr, 0);
    // R1 R4 fill to 16 with varied flags
    for (int i = 1; i <= 16; i++) push(i * 7 + 3);
    chk("R1 full at 16", full, 1);
    // R3 write on full, also with simultaneous read
    push(200);
    chk("R3 overrun set", ovr, 1);
    wr_valid = 1; wr_data = 8'd201; rd = 1; cyc(); wr_valid = 0; rd = 0;
    chk("R3 write dropped while full+read", full, 0);
    cyc(3);
    chk("R3 overrun sticky", ovr, 1);
    // R5 error reset clears flags and overrun, keeps data
    errr = 1; cyc(); errr = 0;
    chk("R5 overrun cleared", ovr, 0);
    chk("R5 head flags cleared", {h_par, h_frm, h_brk}, 0);
    // R4 drain in order, then R10 read on empty
    for (int i = 0; i < 15; i++) pop();
    chk("R4 drained", ready, 0);
    pop(); pop();
    chk("R10 read on empty", {ready, h_data}, 0);
    // R2 half depth
    half = 1; cyc();
    for (int i = 0; i < 10; i++) push(i + 40);
    chk("R2 capacity 8", full, 1);
    chk("R3 overrun at 8", ovr, 1);
    half = 0; cyc();
    chk("R2 capacity back to 16", full, 0);
    for (int i = 0; i < 6; i++) push(i + 90);
    half = 1; cyc(2);
    chk("R2 full with 14 held at cap 8", full, 1);
    // R6 receiver reset empties, overrun untouched
    rxr = 1; wr_valid = 1; cyc(); rxr = 0; wr_valid = 0;
    chk("R6 empty after rx reset", ready, 0);
    chk("R6 overrun kept", ovr, 1);
    errr = 1; cyc(); errr = 0; half = 0; cyc();
    // R7 R8 level programming
    lvl = 2'd1; lvl_wr = 1; cyc(); lvl_wr = 0;
    for (int i = 0; i < 3; i++) push(i + 11);
    chk("R7 half level not reached", fill_irq, 0);
    lvl = 2'd0; lvl_wr = 1; cyc(); lvl_wr = 0;
    cyc(3);
    chk("R8 pending level not yet active", fill_irq, 0);
    push(14);
    chk("R8 pending level active after push", fill_irq, 1);
    lvl = 2'd3; lvl_wr = 1; cyc(); lvl_wr = 0; pop();
    chk("R8 full level after pop", fill_irq, 0);
    for (int i = 0; i < 13; i++) push(i + 60);
    chk("R7 full level reached", fill_irq, 1);
    half = 1; cyc();
    chk("R7 level scaled to 8", fill_irq, 1);
    half = 0; lvl = 2'd2; lvl_wr = 1; cyc(); lvl_wr = 0;
    rxr = 1; cyc(); rxr = 0;
    lvl = 2'd2; lvl_wr = 1; cyc(); lvl_wr = 0;
    for (int i = 0; i < 12; i++) push(i + 120);
    chk("R7 3/4 level at 12", fill_irq, 1);
    rxr = 1; cyc(); rxr = 0; errr = 1; cyc(); errr = 0;
    // R9 watchdog
    wd_en = 1; push(33); tick = 1;
    cyc(WD - 2);
    chk("R9 not yet fired", wd_irq, 0);
    rd = 0; pop();
    push(34); push(35);
    cyc(WD + 4);
    chk("R9 fired after quiet ticks", wd_irq, 1);
    wd_en = 0; cyc();
    chk("R9 gated by enable", wd_irq, 0);
    wd_en = 1; pop();
    chk("R9 cleared by read", wd_irq, 0);
    cyc(WD + 2);
    chk("R9 refires", wd_irq, 1);
    tick = 0; pop(); cyc(WD + 4);
    chk("R9 silent when empty", wd_irq, 0);
    cyc(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule